// File: doc/BRIEF.md
# Event-to-Interrupt Aggregator

This block gathers a wide bundle of single-cycle event pulses and condenses them into a handful of level-sensitive interrupt lines. Each event input owns a programmable steering entry. The entry names one of several wide status words, called virtual interrupt registers, and a bit position inside that word. When an event fires through a valid entry, the chosen bit is latched. The bit then stays set until software clears it.

Every status word has its own enable mask. The word produces one interrupt line, which is the OR of its status bits that are also enabled. A final routing stage connects each output pin to any one of these lines. Software programs the steering entries, the masks, the clears and the routing through a single-cycle write port. It reads masks and status back through a read port whose result arrives one cycle after the request.

Top module: `vint_aggregator`

## Requirements
- R1: After reset, every steering entry is invalid, every mask, status word and route selection is zero, every `irq_out` bit is low, and every read returns zero.
- R2: A write to address `0x000 + e` programs the steering entry of event `e`. The fields are: bit index in `wr_data[5:0]`, register index in `wr_data[8 +: log2(register count)]` (bits `[9:8]` by default), and valid flag in `wr_data[31]`. A pulse on `evt_in[e]` through a valid entry sets the selected status bit at the next clock edge.
- R3: Status bits are sticky. A set bit stays set through any number of idle cycles until it is explicitly cleared.
- R4: A write to address `0x300 + v` clears each bit of status word `v` at which `wr_data` holds a 1, and leaves the other bits alone. If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R5: A write to address `0x200 + v` loads the 64-bit enable mask of word `v`. The interrupt line of word `v` is high exactly when some status bit is set and also enabled. A status bit that is not enabled never raises the line.
- R6: An event whose steering entry is invalid is dropped. It changes no status bit.
- R7: When several events reach the same status bit in one cycle, that bit is set once and no other bit changes.
- R8: A write to address `0x400 + o` selects, through `wr_data[1:0]` by default, which status word's interrupt line drives `irq_out[o]`. The new selection takes effect from the clock edge of the write onwards.
- R9: A read request with `rd_addr` equal to `0x200 + v` returns the mask of word `v`, and one equal to `0x300 + v` returns status word `v`. The value seen is the one held before that edge, and it appears on `rd_data` in the following cycle. Reads of any other address, and cycles with no read request, give zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| evt_in | input | N_EVT | Single-cycle event pulses, one per event |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 12 | Write address: region in bits [11:8], index in bits [7:0] |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 12 | Read address, decoded the same way as the write address |
| rd_data | output | 64 | Read result, valid one cycle after the request |
| irq_out | output | N_OUT | Routed level interrupt lines |

## Verification
The hardest case to reach from the ports is an event that sets a bit in the same cycle that a write-1-to-clear removes that bit. In that case the set must win. It only shows up if the pulse and the clear write share one clock edge. The bench drives both together in a directed step, then reads the word back. A long random phase also overlaps random event bursts with random clears, mask changes, re-steering and rerouting. A behavioural model built from integers and plain arrays checks every output on every cycle. That phase also covers colliding events and events that arrive in the very cycle their steering entry is rewritten.

// File: rtl/vint_pkg.sv
`timescale 1ns/1ps
package vint_pkg;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 8;

  localparam int STEER_REG_LSB   = 8;
  localparam int STEER_VALID_BIT = 31;

  typedef enum logic [3:0] {
    RG_STEER = 4'h0,
    RG_MASK  = 4'h2,
    RG_STAT  = 4'h3,
    RG_ROUTE = 4'h4
  } region_e;

  function automatic logic [3:0] region_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: 4];
  endfunction
endpackage

// File: rtl/vint_steer.sv
`timescale 1ns/1ps
module vint_steer
  import vint_pkg::*;
#(
  parameter int N_EVT  = 128,
  parameter int N_VREG = 4,
  parameter int VW     = 64,
  localparam int BW    = $clog2(VW),
  localparam int RW    = (N_VREG > 1) ? $clog2(N_VREG) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [VW-1:0]                wr_data,
  input  logic [N_EVT-1:0]             evt_in,
  output logic [N_VREG-1:0][VW-1:0]    set_vec
);
  logic          ent_valid [N_EVT];
  logic [BW-1:0] ent_bit   [N_EVT];
  logic [RW-1:0] ent_reg   [N_EVT];

  logic steer_sel;
  assign steer_sel = wr_en && (region_of(wr_addr) == RG_STEER);

  for (genvar e = 0; e < N_EVT; e++) begin : g_ent
    logic          hit;
    logic          valid_r;
    logic [BW-1:0] bit_r;
    logic [RW-1:0] reg_r;

    assign hit = steer_sel && (wr_addr[IDX_W-1:0] == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_r <= 1'b0;
        bit_r   <= '0;
        reg_r   <= '0;
      end else if (hit) begin
        valid_r <= wr_data[STEER_VALID_BIT];
        bit_r   <= wr_data[BW-1:0];
        reg_r   <= wr_data[STEER_REG_LSB +: RW];
      end
    end

    assign ent_valid[e] = valid_r;
    assign ent_bit[e]   = bit_r;
    assign ent_reg[e]   = reg_r;
  end

  // Fold every firing, valid event into a per-register set vector.
  always_comb begin
    set_vec = '0;
    for (int e = 0; e < N_EVT; e++) begin
      if (evt_in[e] && ent_valid[e] && (int'(ent_reg[e]) < N_VREG)) begin
        set_vec[ent_reg[e]][ent_bit[e]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vint_status.sv
`timescale 1ns/1ps
module vint_status
  import vint_pkg::*;
#(
  parameter int N_VREG = 4,
  parameter int VW     = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [VW-1:0]                wr_data,
  input  logic [N_VREG-1:0][VW-1:0]    set_vec,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [N_VREG-1:0][VW-1:0]    clr_vec,
  output logic [N_VREG-1:0][VW-1:0]    status_q,
  output logic [N_VREG-1:0][VW-1:0]    mask_q,
  output logic [N_VREG-1:0]            vline,
  output logic [VW-1:0]                rd_data
);
  for (genvar v = 0; v < N_VREG; v++) begin : g_word
    logic          idx_hit;
    logic          mask_hit;
    logic          stat_hit;
    logic [VW-1:0] stat_r;
    logic [VW-1:0] stat_d;
    logic          stat_en;
    logic [VW-1:0] mask_r;

    assign idx_hit  = wr_en && (wr_addr[IDX_W-1:0] == IDX_W'(v));
    assign mask_hit = idx_hit && (region_of(wr_addr) == RG_MASK);
    assign stat_hit = idx_hit && (region_of(wr_addr) == RG_STAT);
    assign clr_vec[v] = stat_hit ? wr_data : '0;

    // Set wins over clear on the same bit.
    always_comb begin
      stat_d  = (stat_r & ~clr_vec[v]) | set_vec[v];
      stat_en = (|set_vec[v]) || (|clr_vec[v]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_r <= '0;
      end else if (stat_en) begin
        stat_r <= stat_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_r <= '0;
      end else if (mask_hit) begin
        mask_r <= wr_data;
      end
    end

    assign status_q[v] = stat_r;
    assign mask_q[v]   = mask_r;
    assign vline[v]    = |(stat_r & mask_r);
  end

  logic [VW-1:0] rd_d;
  logic [VW-1:0] rd_r;

  always_comb begin
    rd_d = '0;
    if (rd_en) begin
      for (int v = 0; v < N_VREG; v++) begin
        if (rd_addr[IDX_W-1:0] == IDX_W'(v)) begin
          if (region_of(rd_addr) == RG_MASK) rd_d = mask_q[v];
          else if (region_of(rd_addr) == RG_STAT) rd_d = status_q[v];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_r <= '0;
    end else begin
      rd_r <= rd_d;
    end
  end

  assign rd_data = rd_r;
endmodule

// File: rtl/vint_router.sv
`timescale 1ns/1ps
module vint_router
  import vint_pkg::*;
#(
  parameter int N_VREG = 4,
  parameter int N_OUT  = 4,
  parameter int VW     = 64,
  localparam int RW    = (N_VREG > 1) ? $clog2(N_VREG) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [VW-1:0]        wr_data,
  input  logic [N_VREG-1:0]    vline,
  output logic [N_OUT-1:0]     irq_out
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic          hit;
    logic [RW-1:0] sel_r;

    assign hit = wr_en && (region_of(wr_addr) == RG_ROUTE)
                 && (wr_addr[IDX_W-1:0] == IDX_W'(o));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_r <= '0;
      end else if (hit) begin
        sel_r <= wr_data[RW-1:0];
      end
    end

    assign irq_out[o] = (int'(sel_r) < N_VREG) ? vline[sel_r] : 1'b0;
  end
endmodule

// File: rtl/vint_aggregator.sv
`timescale 1ns/1ps
module vint_aggregator
  import vint_pkg::*;
#(
  parameter int N_EVT  = 128,
  parameter int N_VREG = 4,
  parameter int N_OUT  = 4,
  parameter int VW     = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_EVT-1:0]     evt_in,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [VW-1:0]        wr_data,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [VW-1:0]        rd_data,
  output logic [N_OUT-1:0]     irq_out
);
  logic rst_meta;
  logic rst_ni;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  logic [N_VREG-1:0][VW-1:0] set_vec;
  logic [N_VREG-1:0][VW-1:0] clr_vec;
  logic [N_VREG-1:0][VW-1:0] status_q;
  logic [N_VREG-1:0][VW-1:0] mask_q;
  logic [N_VREG-1:0]         vline;

  vint_steer #(.N_EVT(N_EVT), .N_VREG(N_VREG), .VW(VW)) u_steer (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .evt_in  (evt_in),
    .set_vec (set_vec)
  );

  vint_status #(.N_VREG(N_VREG), .VW(VW)) u_status (
    .clk      (clk),
    .rst_n    (rst_ni),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .set_vec  (set_vec),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .clr_vec  (clr_vec),
    .status_q (status_q),
    .mask_q   (mask_q),
    .vline    (vline),
    .rd_data  (rd_data)
  );

  vint_router #(.N_VREG(N_VREG), .N_OUT(N_OUT), .VW(VW)) u_router (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .vline   (vline),
    .irq_out (irq_out)
  );
endmodule

// File: rtl/vint_aggregator_chk.sv
`timescale 1ns/1ps
module vint_aggregator_chk #(
  parameter int N_VREG = 4,
  parameter int VW     = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [N_VREG-1:0][VW-1:0]  set_vec,
  input logic [N_VREG-1:0][VW-1:0]  clr_vec,
  input logic [N_VREG-1:0][VW-1:0]  status_q,
  input logic [N_VREG-1:0][VW-1:0]  mask_q,
  input logic [N_VREG-1:0]          vline,
  input logic                       rd_en,
  input logic [VW-1:0]              rd_data
);
  for (genvar v = 0; v < N_VREG; v++) begin : g_chk
    // R2 and R4: every requested set lands, even against a clear.
    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec[v]) |=> ((status_q[v] & $past(set_vec[v])) == $past(set_vec[v])));

    // R4: cleared bits with no competing set drop.
    a_r4_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_vec[v] & ~set_vec[v])) |=> ((status_q[v] & $past(clr_vec[v] & ~set_vec[v])) == '0));

    // R3: without a clear no status bit falls.
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[v] == '0) |=> ((status_q[v] & $past(status_q[v])) == $past(status_q[v])));

    // R5: a fully masked word keeps its line low.
    a_r5_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[v] == '0) |-> !vline[v]);
  end

  // R9: an idle cycle yields a zero read result.
  a_r9_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0));
endmodule

bind vint_aggregator vint_aggregator_chk #(.N_VREG(N_VREG), .VW(VW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_ni),
  .set_vec  (set_vec),
  .clr_vec  (clr_vec),
  .status_q (status_q),
  .mask_q   (mask_q),
  .vline    (vline),
  .rd_en    (rd_en),
  .rd_data  (rd_data)
);

// File: tb/vint_aggregator_bench.sv
`timescale 1ns/1ps
module vint_aggregator_bench;
  localparam int NE = 128;
  localparam int NV = 4;
  localparam int NO = 4;

  logic            clk;
  logic            rst_n;
  logic [NE-1:0]   evt;
  logic            wr_en;
  logic [11:0]     wr_addr;
  logic [63:0]     wr_data;
  logic            rd_en;
  logic [11:0]     rd_addr;
  logic [63:0]     rd_data;
  logic [NO-1:0]   irq_out;

  vint_aggregator #(.N_EVT(NE), .N_VREG(NV), .N_OUT(NO), .VW(64)) u_vint_aggregator (
    .clk(clk), .rst_n(rst_n), .evt_in(evt), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  string cur_req = "R1";

  // Behavioural reference state
  bit        m_val   [NE];
  int        m_bit   [NE];
  int        m_reg   [NE];
  bit [63:0] m_mask  [NV];
  bit [63:0] m_stat  [NV];
  int        m_route [NO];
  bit [63:0] m_rd;

  task automatic check64(input logic [63:0] act, input logic [63:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    bit [63:0] setv [NV];
    bit [63:0] clrv [NV];
    int rg;
    int ix;
    bit [NO-1:0] exp_irq;
    @(posedge clk);
    for (int v = 0; v < NV; v++) begin setv[v] = '0; clrv[v] = '0; end
    m_rd = '0;
    if (rd_en) begin
      rg = int'(rd_addr[11:8]);
      ix = int'(rd_addr[7:0]);
      if (rg == 2 && ix < NV) m_rd = m_mask[ix];
      else if (rg == 3 && ix < NV) m_rd = m_stat[ix];
    end
    for (int e = 0; e < NE; e++)
      if (evt[e] && m_val[e]) setv[m_reg[e]][m_bit[e]] = 1'b1;
    rg = int'(wr_addr[11:8]);
    ix = int'(wr_addr[7:0]);
    if (wr_en && rg == 3 && ix < NV) clrv[ix] = wr_data;
    for (int v = 0; v < NV; v++) m_stat[v] = (m_stat[v] & ~clrv[v]) | setv[v];
    if (wr_en) begin
      if (rg == 0 && ix < NE) begin
        m_val[ix] = wr_data[31];
        m_bit[ix] = int'(wr_data[5:0]);
        m_reg[ix] = int'(wr_data[9:8]);
      end else if (rg == 2 && ix < NV) begin
        m_mask[ix] = wr_data;
      end else if (rg == 4 && ix < NO) begin
        m_route[ix] = int'(wr_data[1:0]);
      end
    end
    @(negedge clk);
    for (int o = 0; o < NO; o++)
      exp_irq[o] = |(m_stat[m_route[o]] & m_mask[m_route[o]]);
    check64({60'd0, irq_out}, {60'd0, exp_irq}, cur_req);
    check64(rd_data, m_rd, cur_req);
    evt = '0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
  endtask

  task automatic rd(input logic [11:0] a);
    rd_en = 1'b1; rd_addr = a;
    step();
  endtask

  function automatic logic [63:0] steer(input int b, input int r, input bit vld);
    return (64'(vld) << 31) | (64'(r) << 8) | 64'(b);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_en = 1'b0; rd_addr = '0;
    for (int e = 0; e < NE; e++) begin m_val[e] = 0; m_bit[e] = 0; m_reg[e] = 0; end
    for (int v = 0; v < NV; v++) begin m_mask[v] = '0; m_stat[v] = '0; end
    for (int o = 0; o < NO; o++) m_route[o] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    cur_req = "R1";
    check64({60'd0, irq_out}, 64'd0, "R1");
    for (int v = 0; v < NV; v++) begin
      rd(12'h300 + 12'(v)); check64(rd_data, 64'd0, "R1");
      rd(12'h200 + 12'(v)); check64(rd_data, 64'd0, "R1");
    end

    // R2: programming
    cur_req = "R2";
    wr(12'h000, steer(3, 0, 1));
    wr(12'h005, steer(3, 0, 1));
    wr(12'h00A, steer(63, 1, 1));
    wr(12'h07F, steer(0, 3, 1));
    wr(12'h014, steer(7, 2, 0));
    wr(12'h015, steer(9, 2, 1));
    wr(12'h200, '1); wr(12'h201, '1); wr(12'h203, '1);
    for (int o = 0; o < NO; o++) wr(12'h400 + 12'(o), 64'(o));
    rd(12'h201); check64(rd_data, '1, "R5");

    evt[10] = 1'b1; step();
    check_bit(irq_out[1], 1'b1, "R2");
    rd(12'h301); check64(rd_data, 64'h8000_0000_0000_0000, "R2");

    // R7: two events on one bit
    cur_req = "R7";
    evt[0] = 1'b1; evt[5] = 1'b1; step();
    rd(12'h300); check64(rd_data, 64'h8, "R7");

    // R6: invalid entry drops event
    cur_req = "R6";
    evt[20] = 1'b1; step();
    rd(12'h302); check64(rd_data, 64'd0, "R6");
    check_bit(irq_out[2], 1'b0, "R6");

    // R5: masking
    cur_req = "R5";
    evt[21] = 1'b1; step();
    check_bit(irq_out[2], 1'b0, "R5");
    rd(12'h302); check64(rd_data, 64'h200, "R5");
    wr(12'h202, 64'h200);
    check_bit(irq_out[2], 1'b1, "R5");

    // R3: sticky through idle
    cur_req = "R3";
    repeat (6) step();
    check_bit(irq_out[1], 1'b1, "R3");
    rd(12'h301); check64(rd_data, 64'h8000_0000_0000_0000, "R3");

    // R4: clear, and set beating clear
    cur_req = "R4";
    wr(12'h301, '1);
    check_bit(irq_out[1], 1'b0, "R4");
    rd(12'h301); check64(rd_data, 64'd0, "R4");
    evt[0] = 1'b1; wr(12'h300, 64'h8);
    rd(12'h300); check64(rd_data, 64'h8, "R4");
    wr(12'h300, 64'h8);
    rd(12'h300); check64(rd_data, 64'd0, "R4");

    // R8: rerouting
    cur_req = "R8";
    wr(12'h400, 64'd3);
    check_bit(irq_out[0], 1'b0, "R8");
    evt[127] = 1'b1; step();
    check_bit(irq_out[0], 1'b1, "R8");
    check_bit(irq_out[3], 1'b1, "R8");
    wr(12'h400, 64'd1);
    check_bit(irq_out[0], 1'b0, "R8");

    // R9: unmapped reads and read of state before update
    cur_req = "R9";
    rd(12'h500); check64(rd_data, 64'd0, "R9");
    rd(12'h000); check64(rd_data, 64'd0, "R9");
    rd(12'h304); check64(rd_data, 64'd0, "R9");
    evt[10] = 1'b1; rd_en = 1'b1; rd_addr = 12'h301; step();
    check64(rd_data, 64'd0, "R9");
    step(); check64(rd_data, 64'd0, "R9");
    rd(12'h301); check64(rd_data, 64'h8000_0000_0000_0000, "R9");

    // Random mixed traffic against the model
    cur_req = "R2/R3/R4/R5/R7/R8";
    for (int i = 0; i < 4000; i++) begin
      for (int e = 0; e < NE; e++) evt[e] = (($urandom % 24) == 0);
      if (($urandom % 4) == 0) begin
        wr_en = 1'b1;
        wr_data = {$urandom, $urandom};
        case ($urandom % 4)
          0: wr_addr = {4'h0, 8'($urandom % NE)};
          1: wr_addr = {4'h2, 8'($urandom % NV)};
          2: wr_addr = {4'h3, 8'($urandom % NV)};
          default: wr_addr = {4'h4, 8'($urandom % NO)};
        endcase
      end
      if (($urandom % 2) == 0) begin
        rd_en = 1'b1;
        case ($urandom % 4)
          0: rd_addr = {4'h2, 8'($urandom % 6)};
          1: rd_addr = {4'h3, 8'($urandom % 6)};
          2: rd_addr = {4'h3, 8'($urandom % NV)};
          default: rd_addr = {4'h5, 8'($urandom % 6)};
        endcase
      end
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule